// File: doc/BRIEF.md
# Reset Cause Controller

This block combines every reset request of a small chip into one active-low system reset. It also keeps a register with one bit per cause, so software can find out after restart why the reset happened. The internal requests are a window watchdog event, an independent watchdog event, a software request, a low-power security violation and an option-loader request. They are joined by the external reset pin and by the power-on/brown-out indication. A power reset wipes everything, including the cause bits. A system reset leaves the cause bits intact.

The external pin is bidirectional, and its behaviour is set by a two-bit mode field. In the combined mode the pin resets the chip, and every internal request is stretched to a minimum width and driven onto the pin. In the input-only mode the pin still resets the chip, but the chip never drives it. In the GPIO modes the pin plays no part in reset. An optional holder keeps the pin pulled low after the minimum pulse until the chip reads the pin back as low. This helps on a heavily loaded line. The raw pin level is synchronised and glitch-filtered before it counts as a reset. The power-on/brown-out indication is the block's asynchronous reset. Leaving shutdown is signalled on that same input.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Any of the five internal requests, or a valid external pin reset, drives `sys_rst_n` low from the first clock edge that samples it.
- R2: The pin passes through a two-flop synchroniser and becomes a valid external reset only after the synchronised level has been low for FILT_CYCLES (default 4) consecutive cycles. A low of FILT_CYCLES-1 cycles has no effect.
- R3: `rst_flags` bit positions are: 0 pin, 1 window watchdog, 2 independent watchdog, 3 software, 4 low-power security, 5 option loader, 6 power-on. Each source sets its own bit, and the bits keep their value through a system reset.
- R4: While `por_req` is high, `sys_rst_n`, `pwr_rst_n` and `pin_drive_low` are 0, and `rst_flags` reads 7'h40. Both reset outputs return to 1 at the first clock edge after release.
- R5: With `pin_mode` = 2'b00, one internal request drives `pin_drive_low` high for exactly PULSE_CYCLES cycles (default 960).
- R6: A new internal request during an active pulse restarts the count. The pulse then ends PULSE_CYCLES cycles after the last request.
- R7: With `pin_mode` = 2'b01, a pin low resets the chip and sets flag bit 0. Internal requests never drive the pin.
- R8: With `pin_mode` = 2'b10 or 2'b11, a pin low causes no reset and sets no flag, and the pin is never driven.
- R9: With `holder_en` = 1 in mode 2'b00, the pin stays driven after the minimum pulse if the pin was not read low during it. The drive ends once the filtered pin reads low. If the pin was read low during the pulse, there is no extension.
- R10: Flag bit 0 is not set while the block drives the pin, nor until the filtered pin has read high again after the drive ends.
- R11: `flag_clr` zeroes all flags. A source that fires in the same cycle as the clear still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_req | input | 1 | Power-on/brown-out indication, active high, asynchronous |
| pin_in | input | 1 | Raw level read back from the reset pin |
| pin_mode | input | 2 | Pin mode: 00 reset in/out, 01 reset input, 10/11 GPIO |
| holder_en | input | 1 | Keeps the pin low after the pulse until it reads low |
| wwdg_evt | input | 1 | Window watchdog reset request |
| iwdg_evt | input | 1 | Independent watchdog reset request |
| sw_req | input | 1 | Software reset request |
| lpsec_evt | input | 1 | Low-power security violation |
| obl_req | input | 1 | Option-loader reset request |
| flag_clr | input | 1 | Strobe that clears all cause flags |
| sys_rst_n | output | 1 | System reset, active low |
| pwr_rst_n | output | 1 | Power-domain reset, active low |
| pin_drive_low | output | 1 | Output enable pulling the pin low |
| rst_flags | output | 7 | Reset cause flags |

## Verification
The assertions check on every cycle that:
- an internal request leads to a low system reset and a running pulse;
- the pin is driven only in the combined mode;
- the filter changes level only when its count is full;
- the holder engages only when enabled;
- a set bit beats a clear in the flag register;
- the power-domain reset never falls outside a power reset.

The bench scenarios are needed to show the rest:
- the exact pulse length and its restart;
- the filter boundary between three and four low cycles;
- the holder waiting on a loaded line;
- flags surviving a system reset but not a power reset;
- the suppression of the pin flag during and after self-drive.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    typedef enum logic [1:0] {
        PM_INOUT = 2'b00,
        PM_INPUT = 2'b01,
        PM_GPIO  = 2'b10,
        PM_GPIO2 = 2'b11
    } pin_mode_e;

    localparam int unsigned NUM_CAUSE = 7;
    localparam int unsigned IDX_PIN   = 0;
    localparam int unsigned IDX_WWDG  = 1;
    localparam int unsigned IDX_IWDG  = 2;
    localparam int unsigned IDX_SW    = 3;
    localparam int unsigned IDX_LPSEC = 4;
    localparam int unsigned IDX_OBL   = 5;
    localparam int unsigned IDX_POR   = 6;

    function automatic logic mode_is_gpio(input logic [1:0] m);
        return m[1];
    endfunction
endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int unsigned FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic por_i,
    input  logic pin_raw_i,
    output logic pin_low_o
);
    localparam int unsigned CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          level;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_raw_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LIMIT) begin
            st_d.level = st_q.s2;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, level: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_low_o = ~st_q.level;

    // R2
    filt_full_chk: assert property (@(posedge clk) disable iff (por_i)
        (st_q.level != $past(st_q.level)) |-> ($past(st_q.cnt) == LIMIT));
endmodule

// File: rtl/rstc_pulse_gen.sv
module rstc_pulse_gen #(
    parameter int unsigned PULSE_CYCLES = 960
) (
    input  logic clk,
    input  logic por_i,
    input  logic req_i,
    input  logic inout_mode_i,
    input  logic holder_en_i,
    input  logic pin_low_i,
    output logic drive_low_o,
    output logic owned_o,
    output logic active_o
);
    localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hold;
        logic          seen;
        logic          own;
    } pulse_st_t;

    pulse_st_t st_d, st_q;
    logic      drive;

    assign drive = inout_mode_i && ((st_q.cnt != '0) || st_q.hold);

    always_comb begin
        st_d = st_q;
        if (req_i) begin
            st_d.cnt  = LOAD;
            st_d.seen = 1'b0;
            st_d.hold = 1'b0;
        end else begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CW'(1);
                if (pin_low_i) begin
                    st_d.seen = 1'b1;
                end
                if ((st_q.cnt == CW'(1)) && holder_en_i && inout_mode_i
                    && !(st_q.seen || pin_low_i)) begin
                    st_d.hold = 1'b1;
                end
            end
            if (st_q.hold && (pin_low_i || !inout_mode_i)) begin
                st_d.hold = 1'b0;
            end
        end
        if (drive) begin
            st_d.own = 1'b1;
        end else if (!pin_low_i) begin
            st_d.own = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_low_o = drive;
    assign owned_o     = st_q.own || drive;
    assign active_o    = (st_q.cnt != '0) || st_q.hold;

    // R5
    req_starts_pulse_chk: assert property (@(posedge clk) disable iff (por_i)
        req_i |=> active_o);
    // R8
    drive_mode_chk: assert property (@(posedge clk) disable iff (por_i)
        drive_low_o |-> inout_mode_i);
    // R9
    holder_gate_chk: assert property (@(posedge clk) disable iff (por_i)
        $rose(st_q.hold) |-> $past(holder_en_i));
endmodule

// File: rtl/rstc_flag_reg.sv
module rstc_flag_reg #(
    parameter int unsigned  NUM       = 7,
    parameter logic [NUM-1:0] RESET_VAL = '0
) (
    input  logic           clk,
    input  logic           por_i,
    input  logic [NUM-1:0] set_i,
    input  logic           clr_i,
    output logic [NUM-1:0] flags_o
);
    logic [NUM-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = clr_i ? '0 : flags_q;
        flags_d = flags_d | set_i;
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            flags_q <= RESET_VAL;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (por_i)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
    // R11
    clr_empty_chk: assert property (@(posedge clk) disable iff (por_i)
        (clr_i && (set_i == '0)) |=> (flags_o == '0));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (!clr_i && (set_i == '0)) |=> $stable(flags_o));
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rstc_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 960,
    parameter int unsigned FILT_CYCLES  = 4
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       pin_in,
    input  logic [1:0] pin_mode,
    input  logic       holder_en,
    input  logic       wwdg_evt,
    input  logic       iwdg_evt,
    input  logic       sw_req,
    input  logic       lpsec_evt,
    input  logic       obl_req,
    input  logic       flag_clr,
    output logic       sys_rst_n,
    output logic       pwr_rst_n,
    output logic       pin_drive_low,
    output logic [6:0] rst_flags
);
    localparam logic [NUM_CAUSE-1:0] FLAG_RST = NUM_CAUSE'(1) << IDX_POR;

    typedef struct packed {
        logic sys_n;
        logic pwr_n;
    } top_st_t;

    top_st_t st_d, st_q;

    logic pin_low, ext_valid, int_req, inout_mode;
    logic drive, owned, active, pin_evt;
    logic [NUM_CAUSE-1:0] set_vec;

    assign inout_mode = (pin_mode_e'(pin_mode) == PM_INOUT);
    assign int_req    = wwdg_evt | iwdg_evt | sw_req | lpsec_evt | obl_req;

    rstc_pin_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk       (clk),
        .por_i     (por_req),
        .pin_raw_i (pin_in),
        .pin_low_o (pin_low)
    );

    rstc_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk          (clk),
        .por_i        (por_req),
        .req_i        (int_req),
        .inout_mode_i (inout_mode),
        .holder_en_i  (holder_en),
        .pin_low_i    (pin_low),
        .drive_low_o  (drive),
        .owned_o      (owned),
        .active_o     (active)
    );

    assign ext_valid = pin_low && !mode_is_gpio(pin_mode);
    assign pin_evt   = ext_valid && !owned;

    always_comb begin
        set_vec            = '0;
        set_vec[IDX_PIN]   = pin_evt;
        set_vec[IDX_WWDG]  = wwdg_evt;
        set_vec[IDX_IWDG]  = iwdg_evt;
        set_vec[IDX_SW]    = sw_req;
        set_vec[IDX_LPSEC] = lpsec_evt;
        set_vec[IDX_OBL]   = obl_req;
    end

    rstc_flag_reg #(.NUM(NUM_CAUSE), .RESET_VAL(FLAG_RST)) u_flags (
        .clk     (clk),
        .por_i   (por_req),
        .set_i   (set_vec),
        .clr_i   (flag_clr),
        .flags_o (rst_flags)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pwr_n = 1'b1;
        st_d.sys_n = !(int_req || active || ext_valid);
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_rst_n     = st_q.sys_n;
    assign pwr_rst_n     = st_q.pwr_n;
    assign pin_drive_low = drive;

    // R1
    int_req_rst_chk: assert property (@(posedge clk) disable iff (por_req)
        int_req |=> !sys_rst_n);
    // R8
    gpio_quiet_chk: assert property (@(posedge clk) disable iff (por_req)
        (mode_is_gpio(pin_mode) && !int_req && !active) |=> sys_rst_n);
    // R4
    pwr_steady_chk: assert property (@(posedge clk) disable iff (por_req)
        pwr_rst_n |=> pwr_rst_n);
endmodule

// File: tb/rst_cause_ctrl_test.sv
module rst_cause_ctrl_test;
    localparam int PULSE = 24;

    typedef struct packed {
        logic [1:0] mode;
        logic [5:0] src;
        logic [6:0] flags;
        logic       drive;
        logic       rst;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{2'b00, 6'b000010, 7'h02, 1'b1, 1'b1},
        '{2'b00, 6'b000100, 7'h04, 1'b1, 1'b1},
        '{2'b00, 6'b001000, 7'h08, 1'b1, 1'b1},
        '{2'b00, 6'b010000, 7'h10, 1'b1, 1'b1},
        '{2'b00, 6'b100000, 7'h20, 1'b1, 1'b1},
        '{2'b00, 6'b000001, 7'h01, 1'b0, 1'b1},
        '{2'b01, 6'b001000, 7'h08, 1'b0, 1'b1},
        '{2'b01, 6'b000001, 7'h01, 1'b0, 1'b1},
        '{2'b10, 6'b001000, 7'h08, 1'b0, 1'b1},
        '{2'b10, 6'b000001, 7'h00, 1'b0, 1'b0},
        '{2'b11, 6'b000001, 7'h00, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic por_req = 1'b1;
    logic [1:0] pin_mode = 2'b00;
    logic holder_en = 1'b0, wwdg_evt = 1'b0, iwdg_evt = 1'b0, sw_req = 1'b0;
    logic lpsec_evt = 1'b0, obl_req = 1'b0, flag_clr = 1'b0;
    logic ext_low = 1'b0, load_block = 1'b0;
    logic pin_in, sys_rst_n, pwr_rst_n, pin_drive_low;
    logic [6:0] rst_flags;

    int checks = 0, errors = 0, drive_cnt = 0;
    logic saw_drive = 1'b0, saw_rst = 1'b0;

    always #4 clk = ~clk;

    assign pin_in = !(ext_low || (pin_drive_low && !load_block));

    rst_cause_ctrl #(.PULSE_CYCLES(PULSE), .FILT_CYCLES(4)) uut (
        .clk(clk), .por_req(por_req), .pin_in(pin_in), .pin_mode(pin_mode),
        .holder_en(holder_en), .wwdg_evt(wwdg_evt), .iwdg_evt(iwdg_evt),
        .sw_req(sw_req), .lpsec_evt(lpsec_evt), .obl_req(obl_req),
        .flag_clr(flag_clr), .sys_rst_n(sys_rst_n), .pwr_rst_n(pwr_rst_n),
        .pin_drive_low(pin_drive_low), .rst_flags(rst_flags)
    );

    always @(negedge clk) begin
        if (pin_drive_low) begin
            drive_cnt <= drive_cnt + 1;
            saw_drive <= 1'b1;
        end
        if (!sys_rst_n) saw_rst <= 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_marks();
        @(negedge clk);
        saw_drive = 1'b0;
        saw_rst   = 1'b0;
        drive_cnt = 0;
    endtask

    task automatic fire(input logic [5:0] src);
        wwdg_evt = src[1]; iwdg_evt = src[2]; sw_req = src[3];
        lpsec_evt = src[4]; obl_req = src[5];
        @(negedge clk);
        wwdg_evt = 1'b0; iwdg_evt = 1'b0; sw_req = 1'b0;
        lpsec_evt = 1'b0; obl_req = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic ext_pulse(input int n);
        @(negedge clk);
        ext_low = 1'b1;
        repeat (n) @(negedge clk);
        ext_low = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        chk("R4 sys_rst_n in por", int'(sys_rst_n), 0);
        chk("R4 pwr_rst_n in por", int'(pwr_rst_n), 0);
        chk("R4 drive in por", int'(pin_drive_low), 0);
        chk("R4 flags in por", int'(rst_flags), 'h40);
        por_req = 1'b0;
        idle(2);
        chk("R4 pwr_rst_n released", int'(pwr_rst_n), 1);
        chk("R4 sys_rst_n released", int'(sys_rst_n), 1);
        chk("R4 flags after por", int'(rst_flags), 'h40);

        for (int i = 0; i < 11; i++) begin
            pin_mode = VECS[i].mode;
            clear_flags();
            idle(2);
            clear_marks();
            if (VECS[i].src[0]) ext_pulse(10);
            else fire(VECS[i].src);
            idle(60);
            chk($sformatf("R3 R10 table %0d flags", i), int'(rst_flags), int'(VECS[i].flags));
            chk($sformatf("R5 R7 R8 table %0d drive", i), int'(saw_drive), int'(VECS[i].drive));
            chk($sformatf("R1 R8 table %0d sysrst", i), int'(saw_rst), int'(VECS[i].rst));
        end

        pin_mode = 2'b00;
        clear_flags();
        clear_marks();
        fire(6'b001000);
        idle(60);
        chk("R5 pulse width", drive_cnt, PULSE);

        clear_marks();
        fire(6'b001000);
        idle(9);
        fire(6'b001000);
        idle(60);
        chk("R6 restarted width", drive_cnt, PULSE + 10);

        clear_flags();
        clear_marks();
        ext_pulse(3);
        idle(20);
        chk("R2 short glitch flags", int'(rst_flags), 0);
        chk("R2 short glitch sysrst", int'(saw_rst), 0);
        clear_marks();
        ext_pulse(4);
        idle(20);
        chk("R2 min low flags", int'(rst_flags), 1);

        clear_flags();
        holder_en  = 1'b1;
        load_block = 1'b1;
        fire(6'b001000);
        idle(PULSE + 8);
        chk("R9 holder drive", int'(pin_drive_low), 1);
        chk("R9 holder sysrst", int'(sys_rst_n), 0);
        load_block = 1'b0;
        idle(12);
        chk("R9 holder released", int'(pin_drive_low), 0);
        idle(30);
        chk("R10 no pin flag after hold", int'(rst_flags), 'h08);
        clear_marks();
        fire(6'b000100);
        idle(60);
        chk("R9 no extension when seen", drive_cnt, PULSE);
        holder_en = 1'b0;

        clear_flags();
        fire(6'b000100);
        idle(40);
        flag_clr = 1'b1;
        sw_req   = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        sw_req   = 1'b0;
        chk("R11 set beats clear", int'(rst_flags), 'h08);
        chk("R3 flags kept in sys reset", int'(sys_rst_n), 0);
        idle(60);
        chk("R3 flags after sys reset", int'(rst_flags), 'h08);
        clear_flags();
        chk("R11 clear only", int'(rst_flags), 0);

        fire(6'b000010);
        idle(5);
        por_req = 1'b1;
        idle(3);
        chk("R4 por wipes flags", int'(rst_flags), 'h40);
        por_req = 1'b0;
        idle(3);
        chk("R4 flags after second por", int'(rst_flags), 'h40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule